// File: doc/BRIEF.md
# Three-Byte Serial DAC Frame Transmitter

This block is a serial master that delivers one 24-bit word to a digital-to-analog converter over three wires: an active-low frame select, a serial clock and a serial data line. A host presents the word and pulses a start input. The block lowers the frame select and shifts the word out as three back-to-back 8-bit byte transfers. The frame select stays low across the byte boundaries and rises only after the final bit.

Two options are sampled with the start pulse. The edge mode selects which serial clock edge moves the data line. The mirror option reverses the bit order inside each byte, for hosts that hold bytes least significant bit first. The serial clock is derived from the system clock, and each of its half phases lasts `HALF_DIV` system cycles. After the frame select returns high, the block holds it high for one full serial clock period. It then issues a one-cycle done pulse and accepts the next frame.

Top module: `dac_frame_tx`

## Requirements
- R1: After reset, sync_n_o is 1, sclk_o is 0, din_o is 0, busy_o is 0 and done_o is 0.
- R2: With mirror_i at 0, the 24 bits of data_i are sent most significant bit first, as three consecutive 8-bit bytes.
- R3: sync_n_o falls once per frame, in the cycle after start is accepted, and stays low without a break until after the last of the 24 bits. It rises 48*HALF_DIV cycles after the accepting edge.
- R4: A frame produces exactly 24 falling sclk_o edges, which is eight per byte, and sclk_o is 0 whenever no frame is being shifted.
- R5: In edge mode 0 (mode_i = 0, sclk idles low), din_o changes only together with a rising sclk_o edge and is stable at every falling edge, where the receiver samples it.
- R6: In edge mode 1 (mode_i = 1, sclk idles low), the first bit is on din_o before the first rising edge. Later bits change with the falling sclk_o edge, and din_o is stable at every rising edge, where the receiver samples it.
- R7: With mirror_i at 1, each byte is sent least significant bit first, while the bytes keep their order with the most significant byte first. The receiver therefore sees bit i of each byte replaced by bit 7-i.
- R8: Each high phase of sclk_o lasts exactly HALF_DIV system clock cycles.
- R9: busy_o is 1 from the cycle after start is accepted until done_o pulses. A start pulse while busy_o is 1 is ignored: the frame being sent is unchanged, and no extra frame follows.
- R10: After sync_n_o rises it stays high for 2*HALF_DIV cycles. done_o is then 1 for one cycle with busy_o at 0, which is 50*HALF_DIV cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| data_i | input | 24 | Word to send, sampled with start |
| mode_i | input | 1 | Edge mode: 0 = data moves on rising edge, 1 = data moves on falling edge |
| mirror_i | input | 1 | 1 = reverse bit order within each byte |
| busy_o | output | 1 | Frame or hold time in progress |
| done_o | output | 1 | One-cycle pulse at end of hold time |
| sync_n_o | output | 1 | Active-low frame select |
| sclk_o | output | 1 | Serial clock |
| din_o | output | 1 | Serial data |

## Verification
All results are timed from the posedge that accepts start. busy_o and a low sync_n_o appear one register stage later. sync_n_o rises 48*HALF_DIV cycles after that edge, and done_o pulses 50*HALF_DIV cycles after it. The bench counts negedges from the cycle in which it raises start and compares these cycle numbers exactly against the values given here. The received word, the falling-edge count, the high-phase lengths and the data stability are taken from samples at every negedge, one half system clock after the outputs settle. Sweeps cover a walking one across all 24 bits and a set of patterns under every mode and mirror combination.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD
  } tx_state_e;
endpackage

// File: rtl/dac_frame_tick.sv
// Half-period timer: one tick every HALF_DIV cycles while running.
module dac_frame_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF_DIV - 1));
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || wrap)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R8
  half_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/dac_frame_bitsel.sv
// Picks the outgoing bit; optional per-byte bit reversal.
module dac_frame_bitsel #(
  parameter int NBYTES = 3,
  parameter int BYTE_W = 8,
  localparam int WORD_W = NBYTES * BYTE_W,
  localparam int IDX_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              mirror_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] rev_w;
  logic [WORD_W-1:0] src_w;
  logic [IDX_W-1:0]  sel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign rev_w[b*BYTE_W + i] = word_i[b*BYTE_W + BYTE_W - 1 - i];
    end
  end

  assign src_w = mirror_i ? rev_w : word_i;
  assign sel   = IDX_W'(WORD_W - 1) - idx_i;
  assign bit_o = src_w[sel];
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx #(
  parameter int NBYTES   = 3,
  parameter int BYTE_W   = 8,
  parameter int HALF_DIV = 2,
  localparam int WORD_W  = NBYTES * BYTE_W,
  localparam int IDX_W   = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              mode_i,
  input  logic              mirror_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sync_n_o,
  output logic              sclk_o,
  output logic              din_o
);
  import dac_frame_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  tx_state_e         state_q;
  logic              phase_b_q;  // second half of a bit / of the hold period
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;
  logic              mode_q, mirror_q, done_q;
  logic              tick, run, shifting, bit_w;

  assign run      = (state_q != ST_IDLE);
  assign shifting = (state_q == ST_SHIFT);

  dac_frame_tick #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  dac_frame_bitsel #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) bitsel_i (
    .word_i  (word_q),
    .idx_i   (idx_q),
    .mirror_i(mirror_q),
    .bit_o   (bit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_b_q <= 1'b0;
      idx_q     <= '0;
      word_q    <= '0;
      mode_q    <= 1'b0;
      mirror_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          word_q    <= data_i;
          mode_q    <= mode_i;
          mirror_q  <= mirror_i;
          idx_q     <= '0;
          phase_b_q <= 1'b0;
          state_q   <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!phase_b_q) begin
            phase_b_q <= 1'b1;
          end else begin
            phase_b_q <= 1'b0;
            if (idx_q == LAST_IDX) state_q <= ST_HOLD;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        ST_HOLD: if (tick) begin
          if (!phase_b_q) begin
            phase_b_q <= 1'b1;
          end else begin
            phase_b_q <= 1'b0;
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Mode 0: clock high in first half (data moves on rise); mode 1: high in second half.
  assign sclk_o   = shifting && (mode_q ? phase_b_q : !phase_b_q);
  assign din_o    = shifting && bit_w;
  assign sync_n_o = !shifting;
  assign busy_o   = run;
  assign done_o   = done_q;

  // R3
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shifting && !(tick && phase_b_q && idx_q == LAST_IDX)) |=> !sync_n_o);

  // R9
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_n_o) |-> $past(start_i && !busy_o));

  // R5
  mode0_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && $fell(sclk_o)) |-> $stable(din_o));

  // R6
  mode1_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && $rose(sclk_o)) |-> $stable(din_o));

  // R4
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_n_o |-> !sclk_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && sync_n_o && $past(sync_n_o)));

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/dac_frame_tx_tb.sv
module dac_frame_tx_tb_top;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] data_i = '0;
  logic        mode_i = 1'b0;
  logic        mirror_i = 1'b0;
  logic        busy_o, done_o, sync_n_o, sclk_o, din_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dac_frame_tx #(.NBYTES(3), .BYTE_W(8), .HALF_DIV(H)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .data_i(data_i),
    .mode_i(mode_i), .mirror_i(mirror_i), .busy_o(busy_o), .done_o(done_o),
    .sync_n_o(sync_n_o), .sclk_o(sclk_o), .din_o(din_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] flip_bytes(input logic [23:0] w);
    logic [23:0] r;
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < 8; i++)
        r[b*8 + i] = w[b*8 + 7 - i];
    return r;
  endfunction

  // One frame; inject=1 pulses a second start mid-frame with other data.
  task automatic run_frame(input logic [23:0] w, input bit md, input bit mir, input bit inject);
    logic [23:0] rx = '0;
    logic [23:0] exp_w;
    int falls = 0, sfall = 0, srise = 0, run_bad = 0, din_bad = 0;
    int hi_run = 0, rise_n = -1, done_n = -1, done_cnt = 0, busy_at_done = 1, busy1 = 0;
    logic p_sclk, p_sync, p_din;
    @(negedge clk);
    p_sclk = sclk_o; p_sync = sync_n_o; p_din = din_o;
    data_i = w; mode_i = md; mirror_i = mir; start_i = 1'b1;
    for (int n = 1; n <= 52*H + 3; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (inject && n == 10) begin start_i = 1'b1; data_i = ~w; mode_i = ~md; mirror_i = ~mir; end
      if (n == 1) busy1 = busy_o;
      if (p_sync && !sync_n_o) sfall++;
      if (!p_sync && sync_n_o) begin srise++; if (rise_n < 0) rise_n = n; end
      if (p_sclk && !sclk_o) begin
        falls++;
        if (hi_run != H) run_bad++;
        if (!md) begin rx = {rx[22:0], din_o}; if (din_o != p_din) din_bad++; end
      end
      if (!p_sclk && sclk_o) begin
        if (md) begin rx = {rx[22:0], din_o}; if (din_o != p_din) din_bad++; end
      end
      hi_run = sclk_o ? hi_run + 1 : 0;
      if (done_o) begin
        done_cnt++;
        if (done_n < 0) begin done_n = n; busy_at_done = busy_o; end
      end
      p_sclk = sclk_o; p_sync = sync_n_o; p_din = din_o;
    end
    exp_w = mir ? flip_bytes(w) : w;
    if (mir) chk(rx == exp_w, "R7 mirrored word", rx, exp_w);
    else     chk(rx == exp_w, "R2 msb-first word", rx, exp_w);
    chk(falls == 24, "R4 falling edges", falls, 24);
    chk(sfall == 1 && srise == 1, "R3 single sync low window", sfall*16 + srise, 17);
    chk(rise_n == 48*H + 1, "R3 sync rise cycle", rise_n, 48*H + 1);
    chk(run_bad == 0, "R8 high phase length", run_bad, 0);
    if (md) chk(din_bad == 0, "R6 din stable at rise", din_bad, 0);
    else    chk(din_bad == 0, "R5 din stable at fall", din_bad, 0);
    chk(busy1 == 1, "R9 busy after start", busy1, 1);
    chk(done_n == 50*H + 1, "R10 done cycle", done_n, 50*H + 1);
    chk(done_n - rise_n == 2*H, "R10 sync hold length", done_n - rise_n, 2*H);
    chk(busy_at_done == 0 && done_cnt == 1, "R10 done pulse with busy low", busy_at_done*16 + done_cnt, 1);
    if (inject) chk(busy_o == 0 && sync_n_o == 1, "R9 ignored start leaves idle", {busy_o, sync_n_o}, 2'b01);
    chk(sclk_o == 0 && din_o == 0, "R4 idle sclk/din after frame", {sclk_o, din_o}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [23:0] pats [6];
    pats[0] = 24'h000000; pats[1] = 24'hFFFFFF; pats[2] = 24'hA5C30F;
    pats[3] = 24'h123456; pats[4] = 24'h800001; pats[5] = 24'h5AF096;
    repeat (3) @(negedge clk);
    chk(sync_n_o == 1 && sclk_o == 0 && din_o == 0 && busy_o == 0 && done_o == 0,
        "R1 reset outputs", {sync_n_o, sclk_o, din_o, busy_o, done_o}, 5'b10000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(sync_n_o == 1 && sclk_o == 0 && din_o == 0 && busy_o == 0,
        "R1 outputs after release", {sync_n_o, sclk_o, din_o, busy_o}, 4'b1000);
    for (int k = 0; k < 24; k++) run_frame(24'h1 << k, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 6; p++)
        run_frame(pats[p], c[0], c[1], p == 3);
    for (int k = 0; k < 8; k++) run_frame(24'h010101 << k, 1'b1, 1'b1, 1'b0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule